// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio N and emits one single-cycle pulse per N input cycles, the feedback pulse a phase detector compares with a reference. The division is built in the pulse-swallow manner: an internal dual-modulus prescaler counts either P+1 or P input cycles per prescaler cycle, where P is 64 or 128. A swallow count A and a main count B decide how many of each kind make up one output period. A full period consists of B prescaler cycles. The first A of them run at P+1 and the rest run at P, so N = P·B + A.

The three settings are sampled into a shadow copy only at a period boundary, which is the closing edge of the cycle that carries the output pulse. A change made in the middle of a period therefore never bends the current period. If the shadow settings are illegal (B below A, or B below 3), a flag is raised and the pulse stays low. While the flag is up, the shadow copy follows the inputs every cycle, so the block restarts on the first edge that sees legal values. The output is a plain strobe with no handshake. It cannot be stalled and has no back-pressure, and the setting pins are plain levels.

Top module: `pswl_divider`

## Requirements
- R1: While rst_n is low, div_pulse_o is 0 and cfg_err_o is 1. The first rising edge after release samples the settings, cfg_err_o is 0 from then on if they are legal, and the first pulse is high in the N-th cycle after that edge.
- R2: With mod_hi_i = 0 the base modulus is 64, and successive pulses are 64·B + A cycles apart.
- R3: With mod_hi_i = 1 the base modulus is 128, and successive pulses are 128·B + A cycles apart.
- R4: With A = 0 every prescaler cycle uses the base modulus, giving a spacing of exactly P·B cycles.
- R5: With A = B, the largest legal swallow count, every prescaler cycle uses P+1, giving a spacing of B·(P+1) cycles.
- R6: div_pulse_o is high for exactly one input cycle per period, in the last cycle of the period.
- R7: Settings changed during a period leave that period's length unchanged and apply to the next period. Values present during the pulse cycle govern the period that follows.
- R8: cfg_err_o is 1 when the sampled B is less than the sampled A or less than 3 (B = 3 is legal), and no pulse appears while it is 1. Illegal values are taken in only at a period boundary.
- R9: While cfg_err_o is 1, the settings are re-sampled on every edge. Once legal values are applied, cfg_err_o falls after the next edge, and the first pulse is high in the N-th cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| swallow_i | input | 7 | Swallow count A (0 to 127) |
| main_i | input | 11 | Main count B (3 to 2047, at least A) |
| mod_hi_i | input | 1 | Base modulus select: 0 selects 64/65, 1 selects 128/129 |
| div_pulse_o | output | 1 | One-cycle pulse per N input cycles |
| cfg_err_o | output | 1 | Settings illegal, output held low |

## Verification
The period boundary and a settings update can fall in the same cycle. This is the moment the shadow copy is written and the counters restart, and new values may arrive at that same moment. The bench provokes the collision by driving new settings in the very cycle where the pulse is seen high. It judges the outcome by requiring that the next spacing equal the new ratio. A second run changes the settings twenty cycles into a period and requires the current spacing to keep the old ratio. Raising the flag is the other event that shares the boundary: it may only rise directly after a pulse cycle, and the bench confirms that no pulse follows until legal values return.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  localparam int SWL_W_D    = 7;
  localparam int MAIN_W_D   = 11;
  localparam int PLO_LOG2_D = 6;
  localparam int PHI_LOG2_D = 7;
  localparam int MAIN_MIN_D = 3;
endpackage

// File: rtl/pswl_cfg_shadow.sv
module pswl_cfg_shadow #(
  parameter int A_W   = pswl_pkg::SWL_W_D,
  parameter int B_W   = pswl_pkg::MAIN_W_D,
  parameter int B_MIN = pswl_pkg::MAIN_MIN_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           hi_in,
  output logic [A_W-1:0] a_q,
  output logic [B_W-1:0] b_q,
  output logic           hi_q,
  output logic           bad
);
  localparam logic [B_W-1:0] B_FLOOR = B_W'(B_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      hi_q <= 1'b0;
    end else if (load) begin
      a_q  <= a_in;
      b_q  <= b_in;
      hi_q <= hi_in;
    end
  end

  // zeroed shadow after reset counts as illegal, forcing a first capture
  always_comb bad = (b_q < B_W'(a_q)) || (b_q < B_FLOOR);
endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
  parameter int P_LO_LOG2 = pswl_pkg::PLO_LOG2_D,
  parameter int P_HI_LOG2 = pswl_pkg::PHI_LOG2_D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic hi_sel,
  input  logic plus_one,
  output logic wrap
);
  localparam int PC_W = P_HI_LOG2 + 1;
  localparam logic [PC_W-1:0] BASE_LO = PC_W'(1) << P_LO_LOG2;
  localparam logic [PC_W-1:0] BASE_HI = PC_W'(1) << P_HI_LOG2;

  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] limit;

  always_comb begin
    limit = (hi_sel ? BASE_HI : BASE_LO) - PC_W'(1) + PC_W'(plus_one);
    wrap  = !hold && (cnt_q == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (hold || wrap) cnt_q <= '0;
    else                   cnt_q <= cnt_q + PC_W'(1);
  end
endmodule

// File: rtl/pswl_main_ctr.sv
module pswl_main_ctr #(
  parameter int A_W = pswl_pkg::SWL_W_D,
  parameter int B_W = pswl_pkg::MAIN_W_D
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           step,
  input  logic [A_W-1:0] a_lim,
  input  logic [B_W-1:0] b_lim,
  output logic           swallow,
  output logic           last
);
  logic [B_W-1:0] done_q;

  always_comb begin
    swallow = done_q < B_W'(a_lim);
    last    = done_q == (b_lim - B_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    done_q <= '0;
    else if (hold) done_q <= '0;
    else if (step) done_q <= last ? '0 : done_q + B_W'(1);
  end
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
  parameter int A_W       = pswl_pkg::SWL_W_D,
  parameter int B_W       = pswl_pkg::MAIN_W_D,
  parameter int P_LO_LOG2 = pswl_pkg::PLO_LOG2_D,
  parameter int P_HI_LOG2 = pswl_pkg::PHI_LOG2_D,
  parameter int B_MIN     = pswl_pkg::MAIN_MIN_D
) (
  input  logic           clk_in,
  input  logic           rst_n,
  input  logic [A_W-1:0] swallow_i,
  input  logic [B_W-1:0] main_i,
  input  logic           mod_hi_i,
  output logic           div_pulse_o,
  output logic           cfg_err_o
);
  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic           hi_q;
  logic           bad;
  logic           wrap;
  logic           swallow;
  logic           last;
  logic           pulse;

  pswl_cfg_shadow #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) shadow_i (
    .clk(clk_in), .rst_n(rst_n), .load(bad || pulse),
    .a_in(swallow_i), .b_in(main_i), .hi_in(mod_hi_i),
    .a_q(a_q), .b_q(b_q), .hi_q(hi_q), .bad(bad)
  );

  pswl_prescaler #(.P_LO_LOG2(P_LO_LOG2), .P_HI_LOG2(P_HI_LOG2)) pre_i (
    .clk(clk_in), .rst_n(rst_n), .hold(bad),
    .hi_sel(hi_q), .plus_one(swallow), .wrap(wrap)
  );

  pswl_main_ctr #(.A_W(A_W), .B_W(B_W)) main_i_u (
    .clk(clk_in), .rst_n(rst_n), .hold(bad), .step(wrap),
    .a_lim(a_q), .b_lim(b_q), .swallow(swallow), .last(last)
  );

  always_comb begin
    pulse       = wrap && last;
    div_pulse_o = pulse;
    cfg_err_o   = bad;
  end
endmodule

// File: rtl/pswl_divider_chk.sv
module pswl_divider_chk #(
  parameter int A_W       = pswl_pkg::SWL_W_D,
  parameter int B_W       = pswl_pkg::MAIN_W_D,
  parameter int P_LO_LOG2 = pswl_pkg::PLO_LOG2_D,
  parameter int P_HI_LOG2 = pswl_pkg::PHI_LOG2_D
) (
  input logic           clk,
  input logic           rst_n,
  input logic [B_W-1:0] b_in,
  input logic           pulse,
  input logic           err,
  input logic [A_W-1:0] a_sh,
  input logic [B_W-1:0] b_sh,
  input logic           hi_sh
);
  localparam int CW = B_W + P_HI_LOG2 + 2;

  logic [CW-1:0] run_q;
  logic [CW-1:0] n_exp;

  always_comb n_exp = (CW'(b_sh) << (hi_sh ? P_HI_LOG2 : P_LO_LOG2)) + CW'(a_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run_q <= '0;
    else if (err || pulse)  run_q <= CW'(1);
    else                    run_q <= run_q + CW'(1);
  end

  // R2 R3: pulse lands exactly on cycle N counted since the last boundary
  a_r2_period_len: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (run_q == n_exp));
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  a_r7_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !err) |=> ($stable(a_sh) && $stable(b_sh) && $stable(hi_sh)));
  a_r8_err_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(pulse));
  a_r9_err_resamples: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (b_sh == $past(b_in)));
endmodule

bind pswl_divider pswl_divider_chk #(
  .A_W(A_W), .B_W(B_W), .P_LO_LOG2(P_LO_LOG2), .P_HI_LOG2(P_HI_LOG2)
) chk_i (
  .clk(clk_in), .rst_n(rst_n), .b_in(main_i), .pulse(div_pulse_o),
  .err(cfg_err_o), .a_sh(a_q), .b_sh(b_q), .hi_sh(hi_q)
);

// File: tb/pswl_divider_tb.sv
`timescale 1ns/1ps
module pswl_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  a_s = '0;
  logic [10:0] b_s = 11'd3;
  logic        hi_s = 1'b0;
  logic        pulse, flag;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  pswl_divider dut_i (
    .clk_in(clk), .rst_n(rst_n), .swallow_i(a_s), .main_i(b_s),
    .mod_hi_i(hi_s), .div_pulse_o(pulse), .cfg_err_o(flag)
  );

  function automatic int ratio(input bit hi, input int a, input int b);
    return (hi ? 128 : 64) * b + a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input bit hi, input int a, input int b);
    hi_s = hi; a_s = 7'(a); b_s = 11'(b);
  endtask

  task automatic wait_pulse(output int cyc);
    cyc = -1;
    for (int k = 1; k <= 6000; k++) begin
      @(negedge clk);
      if (pulse) begin cyc = k; break; end
    end
  endtask

  task automatic t_reset();
    int k;
    repeat (3) @(negedge clk);
    chk("R1 pulse in reset", pulse, 0);
    chk("R1 flag in reset", flag, 1);
    rst_n = 1'b1;
    k = 0;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (i == 1) chk("R1 flag after first edge", flag, 0);
      if (pulse) begin k = i; break; end
    end
    chk("R1 first pulse cycle", k, 192);
  endtask

  task automatic t_ratio(input bit hi, input int a, input int b, input string req);
    int c;
    wait_pulse(c);
    @(negedge clk);
    set_cfg(hi, a, b);
    wait_pulse(c);
    wait_pulse(c);
    chk(req, c, ratio(hi, a, b));
    @(negedge clk);
    chk("R6 pulse one cycle wide", pulse, 0);
  endtask

  task automatic t_midchange();
    int c, k;
    wait_pulse(c);
    @(negedge clk);
    set_cfg(0, 0, 3);
    wait_pulse(c);
    k = 0;
    for (int i = 1; i <= 6000; i++) begin
      @(negedge clk);
      if (i == 20) set_cfg(1, 2, 3);
      if (pulse) begin k = i; break; end
    end
    chk("R7 old period kept", k, 192);
    wait_pulse(c);
    chk("R7 new period applied", c, 386);
  endtask

  task automatic t_collide();
    int c;
    wait_pulse(c);
    set_cfg(0, 9, 9);
    wait_pulse(c);
    chk("R7 change in pulse cycle", c, 585);
  endtask

  task automatic t_error();
    int c, seen;
    wait_pulse(c);
    @(negedge clk);
    set_cfg(0, 0, 2);
    wait_pulse(c);
    @(negedge clk);
    chk("R8 flag for B below 3", flag, 1);
    seen = 0;
    for (int i = 0; i < 800; i++) begin
      @(negedge clk);
      if (pulse) seen++;
    end
    chk("R8 no pulse while flagged", seen, 0);
    set_cfg(0, 5, 4);
    @(negedge clk);
    chk("R8 flag for B below A", flag, 1);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pulse) seen++;
    end
    chk("R8 still no pulse", seen, 0);
  endtask

  task automatic t_recover();
    int k;
    set_cfg(0, 3, 3);
    k = 0;
    for (int i = 1; i <= 600; i++) begin
      @(negedge clk);
      if (i == 1) chk("R9 flag falls, B=3 legal", flag, 0);
      if (pulse) begin k = i; break; end
    end
    chk("R9 restart spacing", k, 195);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ratio(0, 7, 10, "R2 sel 64 spacing");
    t_ratio(1, 5, 20, "R3 sel 128 spacing");
    t_ratio(0, 0, 5, "R4 zero swallow");
    t_ratio(1, 4, 4, "R5 swallow equals main");
    t_midchange();
    t_collide();
    t_error();
    t_recover();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule